// File: doc/BRIEF.md
# Interrupt Pending and Mask Register Bank

This block gathers 64 level-sensitive interrupt lines into a register bank that software can observe and gate. On every clock edge it copies the level of each source into a pending bit. It keeps a 64-bit mask in which a 1 blocks a source and a 0 lets it through. From these two values it forms one masked request line per source and a single registered "some request is live" flag. The flag goes to the interrupt logic further down the chain.

Software reaches the bank through a small word-addressed register bus. Reads return data one cycle after the strobe. The pending words are read-only. A write to the low mask word that has data bit 0 set is a one-write shortcut: it turns on every mask bit at once. Source 0 is reserved, so its pending bit never becomes set.

Top module: `irq_mask_bank`

## Requirements
- R1: A mask bit of 1 disables its source and a mask bit of 0 enables it. `reqVec[n]` equals pending bit n AND NOT mask bit n, in the same cycle as those register values.
- R2: While `rstN` is low, all 64 mask bits are 1, all pending bits are 0, `anyReq` is 0 and `busRdata` is 0.
- R3: Mask bits 63:32 are read and written at offset 0x8, and mask bits 31:0 at offset 0xC. A write to offset 0x8, or a write to offset 0xC with data bit 0 clear, loads only the addressed word and leaves the other word unchanged.
- R4: A write to offset 0xC with `busWdata[0]` = 1 sets all 64 mask bits to 1, whatever the other data bits hold. A write to offset 0x8 with data bit 0 set only sets mask bit 32.
- R5: On every clock, pending bit n (n ≥ 1) takes the value of `srcLevel[n]`. Pending bits 63:32 read at offset 0x0 and bits 31:0 read at offset 0x4.
- R6: A pending bit follows its source even while its mask bit is 1, and a masked source never drives its `reqVec` bit.
- R7: Pending bit 0 always reads 0, and `reqVec[0]` stays 0 even when `srcLevel[0]` is high and mask bit 0 is clear.
- R8: Writes to offset 0x0 or 0x4 change no register state.
- R9: A read strobe (`busSel`=1, `busWr`=0) loads `busRdata` with the selected word on the next clock edge. `busRdata` holds its value when no read strobe is given. Only `busAddr[3:2]` selects the word.
- R10: `anyReq` equals the OR of `reqVec` as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLevel | input | 64 | Level of each interrupt source |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid one cycle after a read strobe |
| reqVec | output | 64 | Masked request per source |
| anyReq | output | 1 | Registered OR of all masked requests |

## Verification
The sources are driven with alternating nibble patterns, all-ones, a walking single one and an LFSR sequence. The mask is driven with partial words and with the mask-all write. The walking one separates per-bit gating errors from word-level errors. It also exposes a swapped high/low word, because each source lands in exactly one word. All-ones on the sources, together with a cleared mask, is the case that shows whether reserved source 0 leaks through. The mask-all writes are checked by reading back both words. These writes are compared with a write to the high word that has bit 0 set, which must stay local to that word. Pending writes are followed by mask reads, so that a write that should be ignored is seen at the ports.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int BUS_ADDR_W = 4;

  typedef enum logic [1:0] {
    SEL_PEND_HI = 2'd0,
    SEL_PEND_LO = 2'd1,
    SEL_MASK_HI = 2'd2,
    SEL_MASK_LO = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [1:0] wrMask;   // [1] high word, [0] low word
    logic       maskAll;
    logic       rdEn;
    regSel_e    rdSel;
  } bankCtl_t;

endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
(
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [BUS_ADDR_W-1:0] busAddr,
  input  logic                  wrBit0,
  output bankCtl_t              ctl
);

  regSel_e wordSel;
  logic    unusedAddr;

  assign wordSel    = regSel_e'(busAddr[3:2]);
  assign unusedAddr = ^busAddr[1:0];

  always_comb begin
    ctl       = '0;
    ctl.rdSel = wordSel;
    if (busSel) begin
      if (busWr) begin
        unique case (wordSel)
          SEL_MASK_HI: ctl.wrMask[1] = 1'b1;
          SEL_MASK_LO: begin
            if (wrBit0) ctl.maskAll   = 1'b1;
            else        ctl.wrMask[0] = 1'b1;
          end
          default: ;  // pending words are read-only
        endcase
      end else begin
        ctl.rdEn = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_bank_datapath.sv
module irq_bank_datapath
  import irq_bank_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2*REG_W-1:0]    srcLevel,
  input  bankCtl_t              ctl,
  input  logic [REG_W-1:0]      wdata,
  output logic [REG_W-1:0]      rdata,
  output logic [2*REG_W-1:0]    maskBits,
  output logic [2*REG_W-1:0]    pendBits,
  output logic [2*REG_W-1:0]    reqVec,
  output logic                  anyReq
);

  localparam int NUM_SRC   = 2 * REG_W;
  localparam int NUM_WORDS = 2;
  localparam logic [NUM_SRC-1:0] KEEP_MASK = {{(NUM_SRC-1){1'b1}}, 1'b0};

  logic [REG_W-1:0] maskWord [NUM_WORDS];
  logic [REG_W-1:0] pendWord [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskWord[w] <= '1;
        pendWord[w] <= '0;
      end else begin
        pendWord[w] <= srcLevel[w*REG_W +: REG_W] & KEEP_MASK[w*REG_W +: REG_W];
        if (ctl.maskAll)        maskWord[w] <= '1;
        else if (ctl.wrMask[w]) maskWord[w] <= wdata;
      end
    end
    assign maskBits[w*REG_W +: REG_W] = maskWord[w];
    assign pendBits[w*REG_W +: REG_W] = pendWord[w];
  end

  assign reqVec = pendBits & ~maskBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anyReq <= 1'b0;
      rdata  <= '0;
    end else begin
      anyReq <= |reqVec;
      if (ctl.rdEn) begin
        unique case (ctl.rdSel)
          SEL_PEND_HI: rdata <= pendWord[1];
          SEL_PEND_LO: rdata <= pendWord[0];
          SEL_MASK_HI: rdata <= maskWord[1];
          SEL_MASK_LO: rdata <= maskWord[0];
          default:     rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_bank_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2*REG_W-1:0]    srcLevel,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [BUS_ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]      busWdata,
  output logic [REG_W-1:0]      busRdata,
  output logic [2*REG_W-1:0]    reqVec,
  output logic                  anyReq
);

  bankCtl_t           ctl;
  logic [2*REG_W-1:0] maskBits;
  logic [2*REG_W-1:0] pendBits;

  irq_bank_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .wrBit0 (busWdata[0]),
    .ctl    (ctl)
  );

  irq_bank_datapath #(.REG_W(REG_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcLevel(srcLevel),
    .ctl     (ctl),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .maskBits(maskBits),
    .pendBits(pendBits),
    .reqVec  (reqVec),
    .anyReq  (anyReq)
  );

endmodule

// File: rtl/irq_mask_bank_chk.sv
module irq_mask_bank_chk #(
  parameter int REG_W = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2*REG_W-1:0]   srcLevel,
  input logic                 busSel,
  input logic                 busWr,
  input logic [3:0]           busAddr,
  input logic [REG_W-1:0]     busWdata,
  input logic [REG_W-1:0]     busRdata,
  input logic [2*REG_W-1:0]   reqVec,
  input logic                 anyReq,
  input logic [2*REG_W-1:0]   maskBits,
  input logic [2*REG_W-1:0]   pendBits
);

  localparam logic [2*REG_W-1:0] KEEP = {{(2*REG_W-1){1'b1}}, 1'b0};

  // R2: reset state
  assert_reset_state_R2: assert property (@(posedge clk)
    !rstN |=> (&maskBits) && (pendBits == '0) && !anyReq && (busRdata == '0));

  // R4: mask-all write
  assert_mask_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr[3:2] == 2'b11 && busWdata[0]) |=> (&maskBits));

  // R5 and R7: pending capture, bit 0 reserved
  assert_pend_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> pendBits == ($past(srcLevel) & KEEP));

  // R6: masked sources are silent
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec & maskBits) == '0);

  // R8: pending writes leave the mask alone
  assert_pend_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !busAddr[3]) |=> $stable(maskBits));

  // R9: read latency of one cycle
  assert_read_lat_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr[3:2] == 2'b11) |=> busRdata == $past(maskBits[REG_W-1:0]));

  // R10: any-request is the registered OR
  assert_any_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> anyReq == $past(|reqVec));

endmodule

bind irq_mask_bank irq_mask_bank_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_irq_mask_bank.sv
module tb_irq_mask_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcLevel = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] reqVec;
  logic        anyReq;

  int vectors = 0;
  int misses  = 0;

  // behavioural reference state
  logic [63:0] mMask = '1;
  logic [63:0] mPend = '0;
  logic        mAny  = 1'b0;
  logic [31:0] mRd   = '0;
  logic [63:0] curSrc = '0;

  always #5 clk = ~clk;

  irq_mask_bank dut (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .reqVec(reqVec), .anyReq(anyReq)
  );

  task automatic compare(input string tag);
    logic [63:0] expReq;
    expReq = mPend & ~mMask;
    vectors += 3;
    if (reqVec !== expReq) begin
      misses++;
      $display("FAIL %s reqVec actual=%h expected=%h", tag, reqVec, expReq);
    end
    if (anyReq !== mAny) begin
      misses++;
      $display("FAIL %s anyReq actual=%b expected=%b", tag, anyReq, mAny);
    end
    if (busRdata !== mRd) begin
      misses++;
      $display("FAIL %s busRdata actual=%h expected=%h", tag, busRdata, mRd);
    end
  endtask

  task automatic step(input logic sel, input logic wr, input logic [3:0] addr,
                      input logic [31:0] wd, input string tag);
    logic [63:0] nMask;
    compare(tag);
    busSel = sel; busWr = wr; busAddr = addr; busWdata = wd; srcLevel = curSrc;
    if (!rstN) begin
      mMask = '1; mPend = '0; mAny = 1'b0; mRd = '0;
    end else begin
      nMask = mMask;
      if (sel && !wr) begin
        case (addr[3:2])
          2'd0: mRd = mPend[63:32];
          2'd1: mRd = mPend[31:0];
          2'd2: mRd = mMask[63:32];
          default: mRd = mMask[31:0];
        endcase
      end
      if (sel && wr) begin
        if (addr[3:2] == 2'd3 && wd[0]) nMask = '1;
        else if (addr[3:2] == 2'd3)     nMask[31:0] = wd;
        else if (addr[3:2] == 2'd2)     nMask[63:32] = wd;
      end
      mAny  = |(mPend & ~mMask);
      mPend = curSrc & ~64'h1;
      mMask = nMask;
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 4'h0, 32'h0, tag);
  endtask
  task automatic wrReg(input logic [3:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, a, d, tag);
  endtask
  task automatic rdReg(input logic [3:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'h0, tag);
  endtask

  initial begin
    #(200000 * 10);
    misses++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [63:0] lfsr;
    @(negedge clk);
    for (int i = 0; i < 3; i++) idle("R2 reset state");
    rstN = 1'b1;
    rdReg(4'h8, "R2 mask high after reset");
    rdReg(4'hC, "R2 mask low after reset");
    rdReg(4'h4, "R2 pending low after reset");
    idle("R9 read data");

    curSrc = 64'hA5A5_5A5A_0F0F_F0F1;
    idle("R6 capture while masked");
    rdReg(4'h0, "R5 pending high");
    rdReg(4'h4, "R5 pending low");
    idle("R6 masked source silent");

    wrReg(4'hC, 32'h0000_FFF0, "R3 write mask low");
    rdReg(4'hC, "R3 mask low readback");
    rdReg(4'h8, "R3 mask high unchanged");
    idle("R1 gating low word");
    wrReg(4'h8, 32'h0F0F_0000, "R3 write mask high");
    rdReg(4'h8, "R3 mask high readback");
    rdReg(4'hC, "R3 mask low unchanged");
    idle("R1 gating high word");

    wrReg(4'hC, 32'h0000_0000, "R7 clear mask low");
    curSrc = '1;
    idle("R7 source 0 high");
    rdReg(4'h4, "R7 pending bit 0 reads zero");
    idle("R7 no request on source 0");

    wrReg(4'h0, 32'h0000_0000, "R8 write pending high");
    wrReg(4'h4, 32'hFFFF_FFFF, "R8 write pending low");
    rdReg(4'hC, "R8 mask low untouched");
    rdReg(4'h8, "R8 mask high untouched");
    rdReg(4'h0, "R8 pending high untouched");
    idle("R8 settle");

    curSrc = '0;
    idle("R10 sources drop");
    idle("R10 any-request falls");
    curSrc = 64'h0000_0000_0000_0100;
    idle("R10 single source");
    idle("R10 any-request rises");

    wrReg(4'h8, 32'h0000_0001, "R4 high word bit 0 stays local");
    rdReg(4'h8, "R4 high readback");
    rdReg(4'hC, "R4 low unaffected");
    wrReg(4'hC, 32'h0000_0003, "R4 mask-all write");
    rdReg(4'h8, "R4 mask high all ones");
    rdReg(4'hC, "R4 mask low all ones");
    wrReg(4'hC, 32'hFFFF_FFFE, "R3 bit 0 clear after mask-all");
    rdReg(4'hC, "R3 low readback");
    rdReg(4'h8, "R3 high still ones");

    rdReg(4'hD, "R9 low address bits ignored");
    idle("R9 hold without strobe");
    idle("R9 hold without strobe");

    wrReg(4'h8, 32'h0000_0000, "R1 enable all high");
    wrReg(4'hC, 32'h0000_0000, "R1 enable all low");
    for (int n = 0; n < 64; n++) begin
      curSrc = 64'h1 << n;
      idle("R1 walking source");
    end
    idle("R10 walking tail");

    lfsr = 64'hDEAD_BEEF_1234_5679;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      curSrc = lfsr;
      case (k % 5)
        0: wrReg(4'h8, lfsr[63:32], "R3 random mask high");
        1: wrReg(4'hC, lfsr[31:0], "R4 random mask low");
        2: rdReg(4'(k % 16), "R9 random read");
        3: wrReg(4'h4, lfsr[40:9], "R8 random pending write");
        default: idle("R10 random idle");
      endcase
    end
    idle("R5 final");
    compare("R5 final");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule